// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block sequences a microcontroller core through two low-power states, a deep stop (HALT) and a light stop (IDLE). It drives four clock-domain enables: the core clock, the oscillator, a group of high-speed timers and a general-purpose timer. Software requests HALT with a single-cycle request pulse. The request takes effect only if a HALT-enable register has been set. That register takes exactly one write after reset, so a stray later write cannot re-arm or disarm it. IDLE is requested by setting a status-word bit, and the block acts on the rising edge of that bit.

The level of the non-maskable interrupt (NMI) input at the moment of HALT entry decides whether the high-speed timers keep running. Only an NMI rising edge or a reset leaves HALT. Leaving HALT through NMI first restarts the oscillator. The core clock then stays gated until a stabilization counter reaches a programmable limit. IDLE keeps the oscillator running. An NMI rising edge or a general-timer overflow leaves IDLE at once, with no stabilization wait.

Each wake records a 2-bit cause code and pulses a resume strobe for one cycle. Reset is asynchronous. It returns every domain to running, records the reset cause and clears the HALT-enable register.

Top module: `lpm_seq_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, all four enables are 1, `wake_cause` is 2'b01 (reset), `resume` is 0, and the HALT-enable register is cleared and unlocked, so a HALT request is ignored until it is written.
- R2: The first `hen_wr` after reset loads `hen_wdata` into the HALT-enable register. Every later write is ignored: after writing 1 and then 0, HALT still works; after writing 0 and then 1, HALT is still refused.
- R3: A `halt_req` while running, with the HALT-enable register at 0, is ignored and all enables stay 1.
- R4: An accepted `halt_req` with `nmi` high makes all four enables 0 from the next cycle.
- R5: An accepted `halt_req` with `nmi` low makes `hst_en` 1 and the other three enables 0 from the next cycle.
- R6: HALT is left only on an `nmi` rising edge or on reset. `tmr_ovf` pulses and `idle_req` rising edges during HALT change nothing.
- R7: After the `nmi` rising edge that ends HALT, `core_clk_en` stays 0 for `stab_limit`+1 cycles while `osc_en`, `hst_en` and `gtmr_en` are 1. In the following cycle `core_clk_en` is 1, `resume` is 1 and `wake_cause` is 2'b10 (NMI).
- R8: A rising edge of `idle_req` while running enters IDLE from the next cycle, with `core_clk_en` 0 and the other three enables 1. A level held high causes no re-entry.
- R9: An `nmi` rising edge or a `tmr_ovf` pulse during IDLE restores `core_clk_en` in the next cycle, with no stabilization wait. `wake_cause` becomes 2'b10 for NMI or 2'b11 for timer overflow, and NMI wins when both occur together.
- R10: `resume` is a one-cycle pulse, and `wake_cause` changes only in a cycle where `resume` is 1 (apart from reset).
- R11: When an accepted `halt_req` and an `idle_req` rising edge arrive in the same cycle, HALT is entered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, also a wake source |
| halt_req | input | 1 | Software HALT request pulse |
| idle_req | input | 1 | IDLE request bit from the status word, rising edge acts |
| hen_wr | input | 1 | Write strobe of the HALT-enable register |
| hen_wdata | input | 1 | Data for the HALT-enable register |
| nmi | input | 1 | Non-maskable interrupt input, rising edge wakes |
| tmr_ovf | input | 1 | General-timer overflow pulse |
| stab_limit | input | CNT_W | Oscillator stabilization terminal count |
| core_clk_en | output | 1 | Core clock enable |
| osc_en | output | 1 | Oscillator enable |
| hst_en | output | 1 | High-speed timer group enable |
| gtmr_en | output | 1 | General timer enable |
| wake_cause | output | 2 | 01 reset, 10 NMI, 11 timer overflow |
| resume | output | 1 | One-cycle strobe on return to running |

## Verification
The checker watches properties that must hold on every cycle:
- `resume` lasts one cycle, `wake_cause` moves only with it, and the core clock comes back only together with `resume`.
- The HALT-enable value never moves once it is locked, and a refused request leaves the oscillator running.
- HALT persists until an NMI edge, and the timer group's state follows the NMI level at HALT entry.

Only the bench scenarios can show the following:
- The exact length of the stabilization wait for different limits.
- The cause codes and the NMI-over-timer priority on IDLE exit.
- The write-once ordering of the enable register across two resets.
- The HALT-over-IDLE priority.
- An asynchronous reset taken from inside HALT.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_STAB = 2'd2,
    ST_IDLE = 2'd3
  } lpm_state_e;

  localparam logic [1:0] WAKE_NONE  = 2'b00;
  localparam logic [1:0] WAKE_RESET = 2'b01;
  localparam logic [1:0] WAKE_NMI   = 2'b10;
  localparam logic [1:0] WAKE_TOVF  = 2'b11;

  typedef struct packed {
    logic core;
    logic osc;
    logic hst;
    logic gtmr;
  } dom_en_t;

  // Per-state clock-domain enables; hst_keep selects the HALT timer variant.
  function automatic dom_en_t domain_enables(lpm_state_e st, logic hst_keep);
    dom_en_t e;
    case (st)
      ST_RUN:  e = '{core: 1'b1, osc: 1'b1, hst: 1'b1,     gtmr: 1'b1};
      ST_HALT: e = '{core: 1'b0, osc: 1'b0, hst: hst_keep, gtmr: 1'b0};
      ST_STAB: e = '{core: 1'b0, osc: 1'b1, hst: 1'b1,     gtmr: 1'b1};
      default: e = '{core: 1'b0, osc: 1'b1, hst: 1'b1,     gtmr: 1'b1};
    endcase
    return e;
  endfunction

  // IDLE exit cause: NMI has priority over a timer overflow.
  function automatic logic [1:0] idle_wake_cause(logic nmi_edge);
    return nmi_edge ? WAKE_NMI : WAKE_TOVF;
  endfunction

endpackage

// File: rtl/lpm_edge_det.sv
module lpm_edge_det #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= din[i];
    end
    assign rise[i] = din[i] & ~prev_q;
  end
endmodule

// File: rtl/lpm_once_reg.sv
module lpm_once_reg #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q,
  output logic         locked
);
  logic accept;
  assign accept = wr & ~locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q      <= '0;
      locked <= 1'b0;
    end else if (accept) begin
      q      <= wdata;
      locked <= 1'b1;
    end
  end
endmodule

// File: rtl/lpm_stab_ctr.sv
module lpm_stab_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  assign done = run && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run || done)   cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_req,
  input  logic       halt_en,
  input  logic       idle_rise,
  input  logic       nmi_lvl,
  input  logic       nmi_rise,
  input  logic       tmr_ovf,
  input  logic       stab_done,
  output lpm_state_e st_q,
  output logic       hst_keep_q,
  output logic       resume_q,
  output logic [1:0] cause_q,
  output logic       halt_enter
);
  logic idle_enter, idle_wake, stab_wake;

  assign halt_enter = (st_q == ST_RUN) && halt_req && halt_en;
  assign idle_enter = (st_q == ST_RUN) && !halt_enter && idle_rise;
  assign idle_wake  = (st_q == ST_IDLE) && (nmi_rise || tmr_ovf);
  assign stab_wake  = (st_q == ST_STAB) && stab_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_RUN;
      hst_keep_q <= 1'b1;
      resume_q   <= 1'b0;
      cause_q    <= WAKE_RESET;
    end else begin
      resume_q <= 1'b0;
      if (halt_enter) begin
        st_q       <= ST_HALT;
        hst_keep_q <= ~nmi_lvl;
      end else if (idle_enter) begin
        st_q <= ST_IDLE;
      end else if ((st_q == ST_HALT) && nmi_rise) begin
        st_q <= ST_STAB;
      end else if (stab_wake) begin
        st_q     <= ST_RUN;
        resume_q <= 1'b1;
        cause_q  <= WAKE_NMI;
      end else if (idle_wake) begin
        st_q     <= ST_RUN;
        resume_q <= 1'b1;
        cause_q  <= idle_wake_cause(nmi_rise);
      end
    end
  end
endmodule

// File: rtl/lpm_seq_ctrl.sv
module lpm_seq_ctrl
  import lpm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt_req,
  input  logic             idle_req,
  input  logic             hen_wr,
  input  logic             hen_wdata,
  input  logic             nmi,
  input  logic             tmr_ovf,
  input  logic [CNT_W-1:0] stab_limit,
  output logic             core_clk_en,
  output logic             osc_en,
  output logic             hst_en,
  output logic             gtmr_en,
  output logic [1:0]       wake_cause,
  output logic             resume
);
  localparam int NEDGE = 2;

  logic [NEDGE-1:0] edge_in, edge_rise;
  logic             nmi_rise, idle_rise;
  logic             hen_bit, hen_locked;
  logic             stab_done, halt_enter, hst_keep_q;
  lpm_state_e       st_q;
  dom_en_t          en;

  assign edge_in   = {idle_req, nmi};
  assign nmi_rise  = edge_rise[0];
  assign idle_rise = edge_rise[1];

  lpm_edge_det #(.W(NEDGE)) u_edge (
    .clk(clk), .rst_n(rst_n), .din(edge_in), .rise(edge_rise)
  );

  lpm_once_reg #(.W(1)) u_hen (
    .clk(clk), .rst_n(rst_n), .wr(hen_wr), .wdata(hen_wdata),
    .q(hen_bit), .locked(hen_locked)
  );

  lpm_stab_ctr #(.CNT_W(CNT_W)) u_stab (
    .clk(clk), .rst_n(rst_n), .run(st_q == ST_STAB),
    .limit(stab_limit), .done(stab_done)
  );

  lpm_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .halt_en(hen_bit),
    .idle_rise(idle_rise), .nmi_lvl(nmi), .nmi_rise(nmi_rise),
    .tmr_ovf(tmr_ovf), .stab_done(stab_done), .st_q(st_q),
    .hst_keep_q(hst_keep_q), .resume_q(resume), .cause_q(wake_cause),
    .halt_enter(halt_enter)
  );

  assign en          = domain_enables(st_q, hst_keep_q);
  assign core_clk_en = en.core;
  assign osc_en      = en.osc;
  assign hst_en      = en.hst;
  assign gtmr_en     = en.gtmr;
endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk
  import lpm_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       halt_req,
  input logic       nmi,
  input logic       core_clk_en,
  input logic       osc_en,
  input logic       hst_en,
  input logic       resume,
  input logic [1:0] wake_cause,
  input lpm_state_e st_q,
  input logic       hen_bit,
  input logic       hen_locked,
  input logic       nmi_rise,
  input logic       halt_enter
);
  AST_RESUME_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume); // R10
  AST_CAUSE_ONLY_ON_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    !resume |-> $stable(wake_cause)); // R10
  AST_CORE_BACK_WITH_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_clk_en) |-> resume); // R7
  AST_HALT_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && halt_req && !hen_bit) |=> osc_en); // R3
  AST_HEN_WRITE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (hen_locked && $past(hen_locked)) |-> $stable(hen_bit)); // R2
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HALT && !nmi_rise) |=> (st_q == ST_HALT)); // R6
  AST_HALT_NMI_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_enter && nmi) |=> !hst_en && !core_clk_en); // R4
  AST_HALT_NMI_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_enter && !nmi) |=> hst_en && !osc_en); // R5
endmodule

bind lpm_seq_ctrl lpm_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .nmi(nmi),
  .core_clk_en(core_clk_en), .osc_en(osc_en), .hst_en(hst_en),
  .resume(resume), .wake_cause(wake_cause), .st_q(st_q),
  .hen_bit(hen_bit), .hen_locked(hen_locked), .nmi_rise(nmi_rise),
  .halt_enter(halt_enter)
);

// File: tb/lpm_seq_ctrl_bench.sv
module lpm_seq_ctrl_bench;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 0, idle_req = 0, hen_wr = 0, hen_wdata = 0, nmi = 0, tmr_ovf = 0;
  logic [CNT_W-1:0] stab_limit = 8'd5;
  logic core_clk_en, osc_en, hst_en, gtmr_en, resume;
  logic [1:0] wake_cause;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  lpm_seq_ctrl #(.CNT_W(CNT_W)) u_lpm_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .idle_req(idle_req),
    .hen_wr(hen_wr), .hen_wdata(hen_wdata), .nmi(nmi), .tmr_ovf(tmr_ovf),
    .stab_limit(stab_limit), .core_clk_en(core_clk_en), .osc_en(osc_en),
    .hst_en(hst_en), .gtmr_en(gtmr_en), .wake_cause(wake_cause), .resume(resume)
  );

  // Behavioural reference: mode 0 running, 1 deep stop, 2 waiting, 3 light stop
  int m_mode, m_wait;
  bit m_keep, m_res, m_hen, m_lock, m_nmi_p, m_idle_p;
  int m_cause;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_wait = 0; m_keep = 1; m_res = 0; m_cause = 1;
      m_hen = 0; m_lock = 0; m_nmi_p = 0; m_idle_p = 0;
    end else begin
      bit nr, ir;
      nr = nmi && !m_nmi_p;
      ir = idle_req && !m_idle_p;
      m_res = 0;
      if (m_mode == 0) begin
        if (halt_req && m_hen) begin m_mode = 1; m_keep = !nmi; end
        else if (ir) m_mode = 3;
      end else if (m_mode == 1) begin
        if (nr) begin m_mode = 2; m_wait = 0; end
      end else if (m_mode == 2) begin
        if (m_wait == int'(stab_limit)) begin m_mode = 0; m_res = 1; m_cause = 2; end
        else m_wait++;
      end else begin
        if (nr) begin m_mode = 0; m_res = 1; m_cause = 2; end
        else if (tmr_ovf) begin m_mode = 0; m_res = 1; m_cause = 3; end
      end
      if (hen_wr && !m_lock) begin m_hen = hen_wdata; m_lock = 1; end
      m_nmi_p = nmi;
      m_idle_p = idle_req;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Compare against the reference every cycle
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int ec, eo, eh, eg;
      ec = (m_mode == 0);
      eo = (m_mode != 1);
      eh = (m_mode == 1) ? int'(m_keep) : 1;
      eg = (m_mode != 1) && (m_mode != 0) ? 1 : (m_mode == 0);
      chk(core_clk_en == ec, "R4/R5/R7/R8 core_clk_en model", core_clk_en, ec);
      chk(osc_en == eo, "R4/R7 osc_en model", osc_en, eo);
      chk(hst_en == eh, "R4/R5 hst_en model", hst_en, eh);
      chk(gtmr_en == eg, "R4/R8 gtmr_en model", gtmr_en, eg);
      chk(resume == m_res, "R10 resume model", resume, m_res);
      chk(int'(wake_cause) == m_cause, "R9 wake_cause model", wake_cause, m_cause);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_halt();
    halt_req = 1; tick(1); halt_req = 0;
  endtask

  task automatic write_hen(input bit v);
    hen_wr = 1; hen_wdata = v; tick(1); hen_wr = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; tick(3); rst_n = 1; tick(1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(2);
    // R1: reset state
    chk(core_clk_en && osc_en && hst_en && gtmr_en, "R1 enables in reset", core_clk_en, 1);
    do_reset();
    chk(core_clk_en && osc_en && hst_en && gtmr_en, "R1 enables after reset", osc_en, 1);
    chk(wake_cause == 2'b01, "R1 cause after reset", wake_cause, 1);
    chk(resume == 0, "R1 resume after reset", resume, 0);

    // R3: HALT refused while enable clear
    pulse_halt();
    chk(core_clk_en == 1 && osc_en == 1, "R3 halt refused", core_clk_en, 1);
    tick(1);

    // R2: first write 0 locks; later write 1 ignored
    write_hen(0);
    write_hen(1);
    pulse_halt();
    chk(osc_en == 1, "R2 second write ignored", osc_en, 1);
    tick(1);

    // R2/R4: new reset, write 1 then 0, HALT with NMI high
    do_reset();
    write_hen(1);
    write_hen(0);
    nmi = 1; tick(2);
    pulse_halt();
    chk(!core_clk_en && !osc_en && !hst_en && !gtmr_en, "R4 all stopped (R2 lock kept 1)",
        {core_clk_en, osc_en, hst_en, gtmr_en}, 0);

    // R6: timer overflow and idle edge ignored in HALT
    tmr_ovf = 1; idle_req = 1; tick(1); tmr_ovf = 0; tick(2);
    chk(!core_clk_en && !osc_en, "R6 halt holds", osc_en, 0);
    idle_req = 0;
    nmi = 0; tick(2);
    chk(!osc_en, "R6 halt holds on nmi fall", osc_en, 0);

    // R7: NMI rise, stabilization wait of stab_limit+1 cycles
    nmi = 1;
    for (int i = 0; i <= 5; i++) begin
      tick(1);
      chk(!core_clk_en && osc_en && hst_en && gtmr_en, "R7 stabilization wait", core_clk_en, 0);
    end
    tick(1);
    chk(core_clk_en == 1, "R7 core back", core_clk_en, 1);
    chk(resume == 1, "R7 resume on return", resume, 1);
    chk(wake_cause == 2'b10, "R7 cause nmi", wake_cause, 2);
    tick(1);
    chk(resume == 0, "R10 resume one cycle", resume, 0);

    // R5: HALT with NMI low, zero-length limit
    stab_limit = 8'd0;
    nmi = 0; tick(1);
    pulse_halt();
    chk(hst_en && !core_clk_en && !osc_en && !gtmr_en, "R5 timers kept", hst_en, 1);
    nmi = 1; tick(1);
    chk(!core_clk_en && osc_en, "R7 single wait cycle", core_clk_en, 0);
    tick(1);
    chk(core_clk_en && resume, "R7 limit zero return", core_clk_en, 1);
    nmi = 0; tick(2);

    // R8: IDLE on idle_req edge, R9 timer exit
    idle_req = 1; tick(1);
    chk(!core_clk_en && osc_en && hst_en && gtmr_en, "R8 idle enables", core_clk_en, 0);
    tick(3);
    tmr_ovf = 1; tick(1); tmr_ovf = 0;
    chk(core_clk_en && resume, "R9 timer wake no wait", core_clk_en, 1);
    chk(wake_cause == 2'b11, "R9 cause timer", wake_cause, 3);
    tick(3);
    chk(core_clk_en == 1, "R8 held level no reentry", core_clk_en, 1);

    // R9: NMI and timer together
    idle_req = 0; tick(1); idle_req = 1; tick(2);
    chk(!core_clk_en, "R8 second idle", core_clk_en, 0);
    nmi = 1; tmr_ovf = 1; tick(1); tmr_ovf = 0;
    chk(core_clk_en && wake_cause == 2'b10, "R9 nmi priority", wake_cause, 2);
    tick(2);

    // R11: HALT beats IDLE in the same cycle
    idle_req = 0; tick(1);
    halt_req = 1; idle_req = 1; tick(1); halt_req = 0;
    chk(!osc_en && !hst_en, "R11 halt wins", osc_en, 0);
    tick(2);

    // R6/R1: reset leaves HALT and clears the enable register
    rst_n = 0; #1;
    chk(core_clk_en && osc_en && hst_en && gtmr_en, "R6 reset exits halt", osc_en, 1);
    tick(2); rst_n = 1; tick(1);
    chk(wake_cause == 2'b01 && resume == 0, "R1 reset cause", wake_cause, 1);
    pulse_halt();
    chk(osc_en == 1, "R1 enable cleared by reset", osc_en, 1);
    tick(3);
    finish_run();
  end
endmodule